// File: doc/BRIEF.md
# Masked-Domain Post-Increment Address Register

This block is the memory address register of a small stack processor. It holds a 20-bit value in physical form: the value stored is exactly the value driven onto the address bus. Address arithmetic, however, happens in a logical domain. The logical value is the physical value XOR a fixed mask of alternating ones and zeros, `0xAAAAA`.

A load copies a data word into the register unchanged. A fetch-with-post-increment uses the current address for the access. At the following clock edge, the register advances by one in the logical domain and the result is stored back in physical form. As a result, the bus value does not count up by one in its own right. With no control asserted, the register holds its value.

Top module: `xor_addr_reg`

## Requirements
- R1: While `rst_n` is low, the register clears, and after reset `addr` reads physical `0x00000`.
- R2: When `ld_en` is high at a rising edge, `addr` equals `ld_data` after that edge, bit for bit with no mask applied.
- R3: When `inc_en` is high and `ld_en` is low at a rising edge, the new `addr` equals `((old XOR 0xAAAAA) + 1) XOR 0xAAAAA`, with the sum taken modulo 2^20.
- R4: Loading `0x12345` and then incrementing once makes `addr` read `0x1235A`. The logical values are `0xB89EF` before the step and `0xB89F0` after it.
- R5: The logical value wraps. Incrementing physical `0x55555` (logical `0xFFFFF`) gives physical `0xAAAAA` (logical zero). Incrementing physical `0xAAAAA` gives `0xAAAAB`.
- R6: With `ld_en` and `inc_en` both low, `addr` keeps its value across the edge.
- R7: When `ld_en` and `inc_en` are both high, the load wins and `addr` equals `ld_data`.
- R8: The increment is a post-increment. During the cycle in which `inc_en` is asserted, `addr` still shows the pre-increment address. It changes only at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load `ld_data` into the register |
| inc_en | input | 1 | Advance the address by one in the logical domain |
| ld_data | input | 20 | Physical value to load |
| addr | output | 20 | Current physical address driven to the bus |

## Verification
The assertions check the register on every cycle:
- A load always lands unmasked, and takes priority when both controls are asserted.
- Every increment advances the logical value by exactly one.
- An idle cycle leaves the value alone.
- Logical all-ones rolls over to the mask itself.

Some behaviour only the bench scenarios can show:
- The reset value.
- The specific `0x12345` to `0x1235A` worked case.
- The wrap at the other end.
- The post-increment timing, which the bench confirms by sampling the bus mid-cycle while `inc_en` is high.

// File: rtl/xor_addr_reg.sv
module xor_addr_reg #(
  parameter int AW = 20,
  parameter logic [AW-1:0] MASK = 20'hAAAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          inc_en,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] phys_q;
  logic [AW-1:0] logic_cur;
  logic [AW-1:0] phys_inc;

  assign logic_cur = phys_q ^ MASK;
  assign phys_inc  = (logic_cur + AW'(1)) ^ MASK;
  assign addr      = phys_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phys_q <= '0;
    else if (ld_en)  phys_q <= ld_data;
    else if (inc_en) phys_q <= phys_inc;
  end

  AST_LOAD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> addr == $past(ld_data)); // R2 R7

  AST_LOGICAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en) |=> ((addr ^ MASK) == (($past(addr) ^ MASK) + AW'(1)))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !inc_en) |=> $stable(addr)); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en && addr == ~MASK) |=> addr == MASK); // R5

endmodule

// File: tb/xor_addr_reg_tb.sv
`timescale 1ns/1ps
module xor_addr_reg_tb;
  localparam int AW = 20;
  localparam logic [AW-1:0] MSK = 20'hAAAAA;

  typedef struct {
    logic [AW-1:0] val;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0, ld_en = 0, inc_en = 0;
  logic [AW-1:0] ld_data = '0;
  logic [AW-1:0] addr;
  logic [AW-1:0] model = '0;
  exp_t q[$];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  xor_addr_reg u_dut (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .inc_en(inc_en),
                      .ld_data(ld_data), .addr(addr));

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic i, input logic [AW-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    ld_en = l; inc_en = i; ld_data = d;
    if (l) model = d;
    else if (i) model = ((model ^ MSK) + 20'd1) ^ MSK;
    e.val = model; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(addr, e.val, e.tag);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(addr, 20'h00000, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); check(addr, 20'h00000, "R1 after reset");

    drive(1, 0, 20'h12345, "R2 raw load");
    drive(0, 1, 20'h0, "R4 0x12345 step");
    check((model ^ MSK), 20'hB89F0, "R4 logical value");
    drive(0, 1, 20'h0, "R3 second step");
    drive(0, 0, 20'hFFFFF, "R6 hold 1");
    drive(0, 0, 20'h00000, "R6 hold 2");
    drive(1, 1, 20'h0F0F0, "R7 load beats inc");
    drive(1, 0, 20'h55555, "R2 load 55555");
    drive(0, 1, 20'h0, "R5 wrap to AAAAA");
    drive(0, 1, 20'h0, "R5 AAAAA to AAAAB");

    drive(1, 0, 20'h00000, "R2 load zero");
    @(negedge clk); ld_en = 0; inc_en = 1;
    #1 check(addr, 20'h00000, "R8 pre-increment during access");
    model = ((model ^ MSK) + 20'd1) ^ MSK;
    @(posedge clk); #1 check(addr, 20'h00001 ^ 20'h0, model == 20'h00001 ? "R8 after edge" : "R8 model");

    for (int k = 0; k < 40; k++) begin
      logic [2:0] r;
      r = 3'($urandom);
      drive(r == 0, r[2] || r[1], AW'($urandom), r == 0 ? "R2 random load" : (r[2] || r[1]) ? "R3 random step" : "R6 random hold");
    end
    @(negedge clk); ld_en = 0; inc_en = 0;
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule